// File: doc/BRIEF.md
# Flash Read-Mode Output Controller

This block sits on the read path of a parallel NOR flash command interface. The host writes a command byte on the rising edge of the write strobe. That command chooses what later read cycles return: the memory array, the identifier codes, or the status register. The chosen read mode stays in force until another valid command arrives.

During a read, the controller drives a 16-bit data bus and a per-bit output-enable, and takes the data from the source of the current mode. In identifier mode the word offset inside a block selects one of three values: the manufacturer code, a device code set by a density parameter, or that block's lock bit. In status mode one snapshot is taken at the start of each read-enable window. While the external program/erase engine is busy, only the ready flag is driven and the remaining data pins float.

All strobes are active-low and already synchronous to `clk`. Each output is registered, so it reflects the inputs sampled at the previous rising edge.

Top module: `flash_rd_ctrl`

## Requirements
- R1: After reset the mode is read-array and `dq_oe` is 0 (all pins high-impedance).
- R2: A command is taken when `we_n` rises while `ce_n` is low. Code 0xFF selects read-array, 0x90 selects identifier and 0x70 selects status. Any other code, and any `we_n` rise while `ce_n` is high, leaves the mode unchanged.
- R3: The selected mode applies to every later read until another valid command is written.
- R4: In identifier mode, word offset 0 in a block returns 0x0089. Word offset 1 returns the device code: 0x16 for `DENSITY_MBIT`=32, 0x17 for 64 and 0x18 for 128. Bits 15:8 read 0x00 and all 16 bits are driven.
- R5: In identifier mode, word offset 2 returns the addressed block's lock bit on bit 0, with bits 15:1 at zero. Any other word offset returns 0x0000. The word offset is `addr[BLOCK_LSB-1:1]` and the block index is `addr[ADDR_W-1:BLOCK_LSB]`.
- R6: `addr[0]` has no effect on identifier data.
- R7: The status snapshot is taken on the first cycle in which `ce_n` and `oe_n` are both low, whichever strobe falls last. It is held until the read window closes. A new snapshot needs `oe_n` or `ce_n` to go high first.
- R8: Status bit 7 is 1 when `ism_busy` was 0 at the snapshot. If the snapshot saw ready, the bus reads 0x0080 with all 16 bits driven. If it saw busy, only bit 7 is driven (`dq_oe`=0x0080) and it reads 0.
- R9: `dq_oe` is 0 in the cycle after `ce_n` or `oe_n` was sampled high.
- R10: In read-array mode the bus returns `array_rdata` with all 16 bits driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low; command taken on its rise |
| addr | input | ADDR_W | Byte address |
| cmd_data | input | 8 | Command byte written by the host |
| ism_busy | input | 1 | 1 while an operation runs and is not suspended |
| lock_bits | input | 2**(ADDR_W-BLOCK_LSB) | Lock state of each block |
| array_rdata | input | 16 | Data from the array stub for the current address |
| dq_out | output | 16 | Data driven on the bus |
| dq_oe | output | 16 | Per-bit output enable |

## Verification
A mode change takes effect at the clock edge that samples `we_n` high after it was low. Every data and enable result appears one rising edge after the strobes and address that produced it. The bench changes inputs on falling edges and samples at the next falling edge, so exactly one register stage lies between stimulus and check. For the status hold check, the busy input changes mid-window and the bus is sampled two cycles later. That check expects the old snapshot, and it expects the fresh value only after a window closes and reopens.

// File: rtl/flash_rd_pkg.sv
package flash_rd_pkg;
  typedef enum logic [1:0] {
    MODE_ARRAY  = 2'd0,
    MODE_IDENT  = 2'd1,
    MODE_STATUS = 2'd2
  } rd_mode_e;

  localparam logic [7:0] CMD_ARRAY  = 8'hFF;
  localparam logic [7:0] CMD_IDENT  = 8'h90;
  localparam logic [7:0] CMD_STATUS = 8'h70;
  localparam logic [7:0] MFR_CODE   = 8'h89;

  function automatic logic [7:0] dev_code(int mbit);
    case (mbit)
      128:     return 8'h18;
      64:      return 8'h17;
      default: return 8'h16;
    endcase
  endfunction
endpackage

// File: rtl/frd_cmd_latch.sv
module frd_cmd_latch
  import flash_rd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ce_n,
  input  logic       we_n,
  input  logic [7:0] cmd_data,
  output rd_mode_e   mode
);
  logic we_q;
  logic we_rise;

  assign we_rise = !we_q && we_n && !ce_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      we_q <= 1'b1;
      mode <= MODE_ARRAY;
    end else begin
      we_q <= we_n;
      if (we_rise) begin
        case (cmd_data)
          CMD_ARRAY:  mode <= MODE_ARRAY;
          CMD_IDENT:  mode <= MODE_IDENT;
          CMD_STATUS: mode <= MODE_STATUS;
          default:    mode <= mode;
        endcase
      end
    end
  end
endmodule

// File: rtl/frd_status_latch.sv
module frd_status_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_act,
  input  logic busy,
  output logic ready
);
  logic rd_q;
  logic ready_q;
  logic first;

  assign first = rd_act && !rd_q;
  assign ready = first ? !busy : ready_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q    <= 1'b0;
      ready_q <= 1'b1;
    end else begin
      rd_q <= rd_act;
      if (first) ready_q <= !busy;
    end
  end
endmodule

// File: rtl/frd_id_decode.sv
module frd_id_decode
  import flash_rd_pkg::*;
#(
  parameter int ADDR_W       = 22,
  parameter int BLOCK_LSB    = 17,
  parameter int DENSITY_MBIT = 32,
  localparam int NBLK        = 2 ** (ADDR_W - BLOCK_LSB)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [NBLK-1:0]   lock_bits,
  output logic [7:0]        id_byte
);
  localparam logic [7:0] DEV = dev_code(DENSITY_MBIT);

  logic [BLOCK_LSB-1:0]      in_blk;
  logic [BLOCK_LSB-1:0]      word_ofs;
  logic [ADDR_W-BLOCK_LSB-1:0] blk;

  assign in_blk   = addr[BLOCK_LSB-1:0];
  assign word_ofs = in_blk >> 1;
  assign blk      = addr[ADDR_W-1:BLOCK_LSB];

  always_comb begin
    if (word_ofs == BLOCK_LSB'(0))      id_byte = MFR_CODE;
    else if (word_ofs == BLOCK_LSB'(1)) id_byte = DEV;
    else if (word_ofs == BLOCK_LSB'(2)) id_byte = {7'd0, lock_bits[blk]};
    else                                id_byte = 8'h00;
  end
endmodule

// File: rtl/flash_rd_ctrl.sv
module flash_rd_ctrl
  import flash_rd_pkg::*;
#(
  parameter int ADDR_W       = 22,
  parameter int BLOCK_LSB    = 17,
  parameter int DENSITY_MBIT = 32,
  localparam int NBLK        = 2 ** (ADDR_W - BLOCK_LSB),
  localparam int DATA_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        cmd_data,
  input  logic              ism_busy,
  input  logic [NBLK-1:0]   lock_bits,
  input  logic [DATA_W-1:0] array_rdata,
  output logic [DATA_W-1:0] dq_out,
  output logic [DATA_W-1:0] dq_oe
);
  localparam logic [DATA_W-1:0] SR7_MASK = DATA_W'(8'h80);

  rd_mode_e          mode;
  logic              rd_act;
  logic              ready;
  logic [7:0]        id_byte;
  logic [DATA_W-1:0] nxt_out;
  logic [DATA_W-1:0] nxt_oe;

  assign rd_act = !ce_n && !oe_n;

  frd_cmd_latch u_cmd (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n),
    .cmd_data(cmd_data), .mode(mode)
  );

  frd_status_latch u_sts (
    .clk(clk), .rst_n(rst_n), .rd_act(rd_act), .busy(ism_busy), .ready(ready)
  );

  frd_id_decode #(
    .ADDR_W(ADDR_W), .BLOCK_LSB(BLOCK_LSB), .DENSITY_MBIT(DENSITY_MBIT)
  ) u_id (
    .addr(addr), .lock_bits(lock_bits), .id_byte(id_byte)
  );

  always_comb begin
    nxt_out = '0;
    nxt_oe  = '0;
    if (rd_act) begin
      case (mode)
        MODE_IDENT: begin
          nxt_oe  = '1;
          nxt_out = {{(DATA_W-8){1'b0}}, id_byte};
        end
        MODE_STATUS: begin
          nxt_oe  = ready ? '1 : SR7_MASK;
          nxt_out = ready ? SR7_MASK : '0;
        end
        default: begin
          nxt_oe  = '1;
          nxt_out = array_rdata;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dq_out <= '0;
      dq_oe  <= '0;
    end else begin
      dq_out <= nxt_out;
      dq_oe  <= nxt_oe;
    end
  end
endmodule

// File: rtl/frd_checker.sv
module frd_checker
  import flash_rd_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        ce_n,
  input logic        oe_n,
  input logic        we_n,
  input logic [7:0]  cmd_data,
  input rd_mode_e    mode,
  input logic [15:0] dq_out,
  input logic [15:0] dq_oe
);
  logic [1:0] age;
  logic       we_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      age     <= 2'd0;
      we_prev <= 1'b1;
    end else begin
      if (age != 2'd3) age <= age + 2'd1;
      we_prev <= we_n;
    end
  end

  p_hiz_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (age != 2'd0 && $past(ce_n || oe_n)) |-> dq_oe == 16'h0000);

  p_busy_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe != 16'h0000 && dq_oe != 16'hFFFF) |-> (dq_oe == 16'h0080 && dq_out == 16'h0000));

  p_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (age != 2'd0 && $past(mode) != MODE_ARRAY && dq_oe[15]) |-> dq_out[15:8] == 8'h00);

  p_bad_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (age != 2'd0 && !we_prev && we_n && !ce_n && cmd_data != CMD_ARRAY &&
     cmd_data != CMD_IDENT && cmd_data != CMD_STATUS) |=> $stable(mode));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && $past(!ce_n && !oe_n) && $past(!ce_n && !oe_n, 2) &&
     $past(mode) == MODE_STATUS && $past(mode, 2) == MODE_STATUS)
    |-> ($stable(dq_oe) && $stable(dq_out)));
endmodule

bind flash_rd_ctrl frd_checker u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
  .cmd_data(cmd_data), .mode(mode), .dq_out(dq_out), .dq_oe(dq_oe)
);

// File: tb/tb_flash_rd_ctrl.sv
module tb_flash_rd_ctrl;
  localparam int ADDR_W = 22;
  localparam int BLOCK_LSB = 17;
  localparam int NBLK = 2 ** (ADDR_W - BLOCK_LSB);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, ism_busy = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0] cmd_data = 8'h00;
  logic [NBLK-1:0] lock_bits = 32'h0000_0005;
  logic [15:0] array_rdata = 16'hA5C3;
  logic [15:0] dq_out, dq_oe;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  flash_rd_ctrl dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .cmd_data(cmd_data), .ism_busy(ism_busy),
    .lock_bits(lock_bits), .array_rdata(array_rdata),
    .dq_out(dq_out), .dq_oe(dq_oe)
  );

  task automatic chk(string req, logic [15:0] eo, logic [15:0] ee);
    n_chk++;
    if (dq_out !== eo || dq_oe !== ee) begin
      n_bad++;
      $display("FAIL %s: got out=%h oe=%h, expected out=%h oe=%h", req, dq_out, dq_oe, eo, ee);
    end
  endtask

  task automatic cmd_write(logic [7:0] c, logic sel);
    @(negedge clk); ce_n = !sel; we_n = 1'b0; cmd_data = c;
    @(negedge clk); we_n = 1'b1;
    @(negedge clk); ce_n = 1'b1;
  endtask

  task automatic read_chk(logic [ADDR_W-1:0] a, logic [15:0] eo, logic [15:0] ee, string req);
    @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk); chk(req, eo, ee);
    ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk); chk("R1 reset hi-z", 16'h0000, 16'h0000);
    read_chk(22'h000010, 16'hA5C3, 16'hFFFF, "R1 reset array mode");
  endtask

  task automatic t_array;
    array_rdata = 16'h1234;
    read_chk(22'h000200, 16'h1234, 16'hFFFF, "R10 array data");
    array_rdata = 16'hA5C3;
  endtask

  task automatic t_ident;
    cmd_write(8'h90, 1'b1);
    read_chk(22'h000000, 16'h0089, 16'hFFFF, "R4 manufacturer");
    read_chk(22'h000001, 16'h0089, 16'hFFFF, "R6 A0 ignored offset0");
    read_chk(22'h000002, 16'h0016, 16'hFFFF, "R4 device code");
    read_chk(22'h000003, 16'h0016, 16'hFFFF, "R6 A0 ignored offset1");
    read_chk((22'd2 << BLOCK_LSB) | 22'd4, 16'h0001, 16'hFFFF, "R5 block2 locked");
    read_chk((22'd1 << BLOCK_LSB) | 22'd5, 16'h0000, 16'hFFFF, "R5 block1 unlocked");
    read_chk(22'h000006, 16'h0000, 16'hFFFF, "R5 reserved offset");
    read_chk(22'h000000, 16'h0089, 16'hFFFF, "R3 ident mode persists");
  endtask

  task automatic t_cmd_ignore;
    cmd_write(8'hFF, 1'b0);
    read_chk(22'h000000, 16'h0089, 16'hFFFF, "R2 write with ce high ignored");
    cmd_write(8'h70, 1'b1);
    cmd_write(8'h40, 1'b1);
    read_chk(22'h000000, 16'h0080, 16'hFFFF, "R2 invalid code ignored");
    read_chk(22'h012345, 16'h0080, 16'hFFFF, "R3 status mode persists");
  endtask

  task automatic t_status_latch;
    ism_busy = 1'b1;
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk); chk("R8 busy only bit7 driven", 16'h0000, 16'h0080);
    ism_busy = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R7 snapshot held in window", 16'h0000, 16'h0080);
    oe_n = 1'b1;
    @(negedge clk); chk("R9 oe high hi-z", 16'h0000, 16'h0000);
    oe_n = 1'b0;
    @(negedge clk); chk("R7 fresh after oe toggle", 16'h0080, 16'hFFFF);
    ce_n = 1'b1;
    ism_busy = 1'b1;
    @(negedge clk); chk("R9 ce high hi-z", 16'h0000, 16'h0000);
    ce_n = 1'b0;
    @(negedge clk); chk("R7 snapshot on ce edge", 16'h0000, 16'h0080);
    ce_n = 1'b1; oe_n = 1'b1; ism_busy = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_idle;
    cmd_write(8'hFF, 1'b1);
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b1;
    @(negedge clk); chk("R9 ce low oe high hi-z", 16'h0000, 16'h0000);
    ce_n = 1'b1;
    read_chk(22'h000002, 16'hA5C3, 16'hFFFF, "R2 back to array");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_array();
    t_ident();
    t_cmd_ignore();
    t_status_latch();
    t_idle();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule